// File: doc/BRIEF.md
# Window Threshold Interrupt with Persistence

This block watches the stream of finished conversion results from a light-measurement converter and decides when to raise an alarm. Each result carries a valid pulse. The upper byte of the result is compared against two programmable 8-bit bounds. A reading above the upper bound or below the lower bound counts as a window violation.

A single violation does not raise the alarm. The block counts consecutive violating results, and it asserts the interrupt only when that count reaches a run length chosen by a 2-bit persistence code. Short spikes, such as a camera flash, are therefore filtered out. Once asserted, the interrupt stays latched until software pulses the clear strobe. The interrupt pin is active low and open-drain, so the block drives only a pull-down enable. The same state is also available as a readable flag.

Top module: `wdw_irq`

## Requirements
- R1: While reset is asserted, `int_pull_en` and `int_flag` are 0 and the violation run count is zeroed. After reset is released, a full run of violations is needed again before the interrupt asserts.
- R2: Only bits [15:8] of `res_data` are compared. A reading violates when those bits are greater than `thr_hi` or less than `thr_lo`. A value equal to either bound is inside the window, and bits [7:0] have no effect.
- R3: `persist_code` sets the required run length: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 16 consecutive violating results.
- R4: A valid result that is inside the window resets the run count to zero.
- R5: Cycles without `res_valid` leave the run count unchanged. They neither advance it nor reset it.
- R6: Once `int_flag` is 1, it stays 1 while `int_clr` is 0, even when later readings are inside the window.
- R7: A cycle with `int_clr` high and no qualifying violation makes `int_flag` 0 from the next cycle on.
- R8: When `int_clr` arrives in the same cycle as a qualifying violation, `int_flag` stays or becomes 1.
- R9: `int_pull_en` equals `int_flag`. A value of 1 means the active-low pin is pulled low.
- R10: `int_flag` rises in the cycle after the clock edge that samples the qualifying valid result, and never without one.
- R11: The run count saturates at the required length. After the interrupt has been cleared, each further violating result re-asserts it while the run continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | One-cycle pulse marking a finished conversion |
| res_data | input | 16 | Conversion result |
| thr_hi | input | 8 | Upper window bound |
| thr_lo | input | 8 | Lower window bound |
| persist_code | input | 2 | Run-length select (1/4/8/16) |
| int_clr | input | 1 | Interrupt clear strobe |
| int_pull_en | output | 1 | Pull-down enable for the active-low open-drain pin |
| int_flag | output | 1 | Readable latched interrupt state |

## Verification
The embedded properties check, on every cycle, the following behaviour:
- the run count never passes its ceiling and is reset by an inside reading;
- the run count is frozen on idle cycles;
- the flag is held until cleared, is dropped by a clear that meets no violation and is forced by any qualifying violation;
- the flag never rises without a sampled valid result.

Only the bench scenarios can show that the comparison uses the upper byte with inclusive bounds, and that each persistence code yields exactly its run length. The same applies to a reset mid-run forcing a fresh count and to saturation re-asserting the flag after a clear.

// File: rtl/wdw_irq_pkg.sv
package wdw_irq_pkg;

    localparam int DEF_RES_W  = 16;
    localparam int DEF_THR_W  = 8;
    localparam int DEF_CODE_W = 2;

    typedef enum logic [1:0] {
        WIN_INSIDE = 2'd0,
        WIN_ABOVE  = 2'd1,
        WIN_BELOW  = 2'd2
    } win_e;

endpackage

// File: rtl/wdw_irq_cmp.sv
module wdw_irq_cmp
    import wdw_irq_pkg::*;
#(
    parameter int RES_W = DEF_RES_W,
    parameter int THR_W = DEF_THR_W
) (
    input  logic [RES_W-1:0] res_data,
    input  logic [THR_W-1:0] thr_hi,
    input  logic [THR_W-1:0] thr_lo,
    output win_e             win
);

    logic [THR_W-1:0] top_bits;

    // Take the most significant THR_W bits of the result (R2)
    generate
        if (RES_W > THR_W) begin : g_slice
            assign top_bits = res_data[RES_W-1 -: THR_W];
        end else begin : g_full
            assign top_bits = THR_W'(res_data);
        end
    endgenerate

    always_comb begin
        if (top_bits > thr_hi) begin
            win = WIN_ABOVE;
        end else if (top_bits < thr_lo) begin
            win = WIN_BELOW;
        end else begin
            win = WIN_INSIDE;
        end
    end

endmodule

// File: rtl/wdw_irq_run.sv
module wdw_irq_run
    import wdw_irq_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  win_e              win,
    input  logic [CODE_W-1:0] persist_code,
    output logic              qualify
);

    localparam int MAX_RUN = 1 << (1 << CODE_W);
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] run;
    } run_state_t;

    run_state_t       st_d, st_q;
    logic [CNT_W-1:0] need;
    logic [CNT_W:0]   run_inc;
    logic             violated;

    always_comb begin
        // code 0 -> 1, code k -> 2^(k+1)  (R3)
        if (persist_code == '0) begin
            need = CNT_W'(1);
        end else begin
            need = CNT_W'(1) << ({1'b0, persist_code} + 1'b1);
        end
        violated = (win != WIN_INSIDE);
        run_inc  = {1'b0, st_q.run} + 1'b1;
        qualify  = res_valid && violated && (run_inc >= {1'b0, need});

        st_d = st_q;
        if (res_valid) begin
            if (!violated) begin
                st_d.run = '0;
            end else if (run_inc > {1'b0, need}) begin
                st_d.run = need;
            end else begin
                st_d.run = run_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_run_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= CNT_W'(MAX_RUN));

    assert_inside_clears_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && win == WIN_INSIDE) |=> (st_q.run == '0));

    assert_idle_holds_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(st_q.run));

endmodule

// File: rtl/wdw_irq_latch.sv
module wdw_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic qualify,
    input  logic int_clr,
    output logic flag
);

    typedef struct packed {
        logic flag;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a qualifying violation outranks the clear (R8)
        st_d.flag = qualify | (st_q.flag & ~int_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    assert_hold_until_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !int_clr) |=> st_q.flag);

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !qualify) |=> !st_q.flag);

    assert_violation_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        qualify |=> st_q.flag);

    assert_rise_needs_qualify_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(qualify));

endmodule

// File: rtl/wdw_irq.sv
module wdw_irq
    import wdw_irq_pkg::*;
#(
    parameter int RES_W  = DEF_RES_W,
    parameter int THR_W  = DEF_THR_W,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic [THR_W-1:0]  thr_hi,
    input  logic [THR_W-1:0]  thr_lo,
    input  logic [CODE_W-1:0] persist_code,
    input  logic              int_clr,
    output logic              int_pull_en,
    output logic              int_flag
);

    win_e win;
    logic qualify;
    logic flag;

    wdw_irq_cmp #(
        .RES_W (RES_W),
        .THR_W (THR_W)
    ) i_cmp (
        .res_data (res_data),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .win      (win)
    );

    wdw_irq_run #(
        .CODE_W (CODE_W)
    ) i_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .win          (win),
        .persist_code (persist_code),
        .qualify      (qualify)
    );

    wdw_irq_latch i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .qualify (qualify),
        .int_clr (int_clr),
        .flag    (flag)
    );

    // open-drain pin: enable the pull-down while the alarm is latched (R9)
    assign int_pull_en = flag;
    assign int_flag    = flag;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!int_flag && !int_pull_en));

    assert_rise_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_flag) |-> $past(res_valid));

endmodule

// File: tb/test_wdw_irq.sv
`timescale 1ns/1ps
module test_wdw_irq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [15:0] res_data;
    logic [7:0]  thr_hi;
    logic [7:0]  thr_lo;
    logic [1:0]  persist_code;
    logic        int_clr;
    logic        int_pull_en;
    logic        int_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdw_irq i_wdw_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .thr_hi       (thr_hi),
        .thr_lo       (thr_lo),
        .persist_code (persist_code),
        .int_clr      (int_clr),
        .int_pull_en  (int_pull_en),
        .int_flag     (int_flag)
    );

    typedef struct packed {
        logic        clr;
        logic        valid;
        logic [15:0] data;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [1:0]  code;
        logic        exp;
    } vec_t;

    localparam int NV = 20;
    // window 0x20..0x80; expected flag after the edge that samples the row
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 0 run 1
        '{1'b0, 1'b1, 16'h1000, 8'h80, 8'h20, 2'd1, 1'b0}, // 1 run 2 (below)
        '{1'b0, 1'b0, 16'hFFFF, 8'h80, 8'h20, 2'd1, 1'b0}, // 2 idle, R5
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 3 run 3
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b1}, // 4 run 4 -> assert
        '{1'b0, 1'b1, 16'h5000, 8'h80, 8'h20, 2'd1, 1'b1}, // 5 inside, latched R6
        '{1'b1, 1'b0, 16'h0000, 8'h80, 8'h20, 2'd1, 1'b0}, // 6 clear R7
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 7 run 1
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 8 run 2
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 9 run 3
        '{1'b0, 1'b1, 16'h5000, 8'h80, 8'h20, 2'd1, 1'b0}, // 10 inside resets R4
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 11 run 1
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 12 run 2
        '{1'b0, 1'b1, 16'h9000, 8'h80, 8'h20, 2'd1, 1'b0}, // 13 run 3
        '{1'b0, 1'b1, 16'h80FF, 8'h80, 8'h20, 2'd1, 1'b0}, // 14 equal hi inside R2
        '{1'b0, 1'b1, 16'h8100, 8'h80, 8'h20, 2'd0, 1'b1}, // 15 code0 run 1 R3
        '{1'b1, 1'b1, 16'h1F00, 8'h80, 8'h20, 2'd0, 1'b1}, // 16 clear + violation R8
        '{1'b1, 1'b0, 16'h0000, 8'h80, 8'h20, 2'd0, 1'b0}, // 17 clear R7
        '{1'b0, 1'b1, 16'h7FFF, 8'h80, 8'h20, 2'd0, 1'b0}, // 18 low byte ignored R2
        '{1'b0, 1'b1, 16'h2000, 8'h80, 8'h20, 2'd0, 1'b0}  // 19 equal lo inside R2
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_both(input string tag, input logic exp);
        check(tag, int_flag, exp);
        check({tag, " R9 pull"}, int_pull_en, exp);
    endtask

    task automatic step(input logic clr, input logic valid, input logic [15:0] data);
        int_clr   = clr;
        res_valid = valid;
        res_data  = data;
        @(negedge clk);
    endtask

    task automatic violations(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b1, 16'hC000);
    endtask

    initial begin
        rst_n = 1'b0; res_valid = 1'b0; res_data = '0; int_clr = 1'b0;
        thr_hi = 8'h80; thr_lo = 8'h20; persist_code = 2'd1;
        repeat (3) @(negedge clk);
        check_both("R1 reset state", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk (R2 R3 R4 R5 R6 R7 R8 R10)
        for (int i = 0; i < NV; i++) begin
            thr_hi = VECS[i].hi; thr_lo = VECS[i].lo; persist_code = VECS[i].code;
            step(VECS[i].clr, VECS[i].valid, VECS[i].data);
            check_both($sformatf("vector %0d R10", i), VECS[i].exp);
        end

        // R1: reset mid-run forces a fresh count
        thr_hi = 8'h80; thr_lo = 8'h20; persist_code = 2'd1;
        step(1'b1, 1'b0, 16'h0);
        violations(3);
        check_both("R1 pre-reset run 3", 1'b0);
        rst_n = 1'b0; step(1'b0, 1'b0, 16'h0);
        check_both("R1 reset mid-run", 1'b0);
        rst_n = 1'b1; step(1'b0, 1'b0, 16'h0);
        violations(3);
        check_both("R1 run zeroed", 1'b0);
        violations(1);
        check_both("R3 code1 fourth", 1'b1);
        rst_n = 1'b0; step(1'b0, 1'b0, 16'h0);
        check_both("R1 reset clears flag", 1'b0);
        rst_n = 1'b1; step(1'b0, 1'b0, 16'h0);

        // R3 code 2 -> 8, then R11 saturation
        persist_code = 2'd2;
        violations(7);
        check_both("R3 code2 seventh", 1'b0);
        violations(1);
        check_both("R3 code2 eighth", 1'b1);
        step(1'b1, 1'b0, 16'h0);
        check_both("R7 clear after code2", 1'b0);
        violations(1);
        check_both("R11 saturated re-assert", 1'b1);

        // R3 code 3 -> 16
        persist_code = 2'd3;
        step(1'b1, 1'b1, 16'h5000);
        check_both("R4 clear with inside", 1'b0);
        violations(15);
        check_both("R3 code3 fifteenth", 1'b0);
        violations(1);
        check_both("R3 code3 sixteenth", 1'b1);

        // R10: no change before the sampling edge
        persist_code = 2'd0;
        step(1'b1, 1'b0, 16'h0);
        int_clr = 1'b0; res_valid = 1'b1; res_data = 16'h0500;
        #1;
        check_both("R10 before edge", 1'b0);
        @(negedge clk);
        check_both("R10 after edge", 1'b1);
        step(1'b0, 1'b0, 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule